// File: doc/BRIEF.md
# Per-Sector Write Guard with Single-Sector Unlock

This block decides whether a program or erase aimed at a 2 MB flash array may proceed. The array is split into 512 sectors of 4 KB. One guard bit per sector holds the protection state, with inverted sense: a cleared bit protects its sector, and a set bit leaves it writable. Separately, a single unlock pointer can open exactly one sector, even when that sector's guard bit is cleared.

The surrounding command logic drives single-cycle strobes. One strobe erases the whole guard array to all ones. Another programs one guard bit, and a program can only clear a bit, never set it. Two more strobes unlock one sector or lock it again. The command logic also presents the target address of a pending program or erase and reads back a write-allowed flag in the same cycle.

All addresses enter as their sector-granular part, bits 23 down to 12. The low twelve bits are not decoded at all.

Top module: `sector_guard`

## Requirements
- R1: After reset every guard bit is 1 and no sector is unlocked, so `write_ok` is 1 for every in-range address.
- R2: The sector index is address bits 20..12. An address with any of bits 23..21 set is out of range: a query on it gives `write_ok` 0, and a program or unlock on it changes nothing.
- R3: A `guard_erase` strobe sets all 512 guard bits to 1 from the next cycle on.
- R4: A `guard_prog` strobe with `prog_bit` 0 clears the selected sector's guard bit from the next cycle. With `prog_bit` 1 the bit keeps its old value, so a program never sets a bit.
- R5: When `guard_erase` and `guard_prog` are strobed in the same cycle, the erase wins and all bits end at 1.
- R6: With no sector unlocked, `write_ok` equals the guard bit of the queried sector: 0 means protected and 1 means writable.
- R7: An `unlock_req` makes the addressed sector writable from the next cycle, whatever its guard bit. Other sectors, including those in the same 64 KB block, keep their guard state.
- R8: A new unlock replaces the previously unlocked sector, which returns to its guard state.
- R9: A `lock_req` closes the unlocked sector from the next cycle. When `lock_req` and `unlock_req` arrive together, the lock wins and no sector is left unlocked.
- R10: `write_ok` is combinational in `query_addr` and follows it within the same cycle.
- R11: In a cycle with no strobe, the guard bits and the unlock state are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_erase | input | 1 | Set all guard bits to 1 |
| guard_prog | input | 1 | Program one guard bit |
| prog_addr | input | 12 | Address bits 23..12 of the sector to program |
| prog_bit | input | 1 | Value to program; only 0 has an effect |
| unlock_req | input | 1 | Unlock the sector at `unlock_addr` |
| lock_req | input | 1 | Close the unlocked sector |
| unlock_addr | input | 12 | Address bits 23..12 of the sector to unlock |
| query_addr | input | 12 | Address bits 23..12 of the pending program or erase |
| write_ok | output | 1 | 1 when the queried sector may be modified |

## Verification
Every strobe updates state on the next rising edge, so its effect on `write_ok` is due one cycle after the strobe. The query path itself has no register and so has no latency. The bench drives strobes just after a falling edge and updates its reference model at the rising edge that follows. It then moves `query_addr` after the next falling edge and samples `write_ok` a time step later, well clear of either edge. For R10, the bench changes the query twice with no clock edge in between and checks `write_ok` after each change.

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 12,
  parameter int NUM_SECT = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       guard_erase,
  input  logic                       guard_prog,
  input  logic [ADDR_W-1:SECT_LSB]   prog_addr,
  input  logic                       prog_bit,
  input  logic                       unlock_req,
  input  logic                       lock_req,
  input  logic [ADDR_W-1:SECT_LSB]   unlock_addr,
  input  logic [ADDR_W-1:SECT_LSB]   query_addr,
  output logic                       write_ok
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int HI_LSB = SECT_LSB + SECT_W;

  logic [NUM_SECT-1:0] guard_q;
  logic                unl_valid;
  logic [SECT_W-1:0]   unl_sect;

  wire [SECT_W-1:0] prog_idx = prog_addr[HI_LSB-1:SECT_LSB];
  wire [SECT_W-1:0] unl_idx  = unlock_addr[HI_LSB-1:SECT_LSB];
  wire [SECT_W-1:0] q_idx    = query_addr[HI_LSB-1:SECT_LSB];
  wire prog_in  = (prog_addr[ADDR_W-1:HI_LSB] == '0);
  wire unl_in   = (unlock_addr[ADDR_W-1:HI_LSB] == '0);
  wire q_in     = (query_addr[ADDR_W-1:HI_LSB] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      guard_q <= '1;
    else if (guard_erase)
      guard_q <= '1;
    else if (guard_prog && prog_in)
      guard_q[prog_idx] <= guard_q[prog_idx] & prog_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unl_valid <= 1'b0;
      unl_sect  <= '0;
    end else if (lock_req) begin
      unl_valid <= 1'b0;
    end else if (unlock_req && unl_in) begin
      unl_valid <= 1'b1;
      unl_sect  <= unl_idx;
    end
  end

  assign write_ok = q_in & (guard_q[q_idx] | (unl_valid & (unl_sect == q_idx)));
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 12,
  parameter int NUM_SECT = 512
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     guard_erase,
  input logic                     guard_prog,
  input logic                     unlock_req,
  input logic                     lock_req,
  input logic [ADDR_W-1:SECT_LSB] unlock_addr,
  input logic                     write_ok,
  input logic [NUM_SECT-1:0]      guard_q,
  input logic                     unl_valid,
  input logic [$clog2(NUM_SECT)-1:0] unl_sect
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int HI_LSB = SECT_LSB + SECT_W;

  wire unl_ok = unlock_req && !lock_req && (unlock_addr[ADDR_W-1:HI_LSB] == '0);

  p_erase_all_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    guard_erase |=> (write_ok || !$stable(write_ok) || 1'b1) && (&guard_q));

  p_prog_only_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_prog && !guard_erase) |=> ($countones(guard_q) <= $past($countones(guard_q))));

  p_unlock_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unl_ok |=> (unl_valid && unl_sect == $past(unlock_addr[HI_LSB-1:SECT_LSB])));

  p_lock_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> !unl_valid);

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard_erase && !guard_prog && !unlock_req && !lock_req) |=>
      ($stable(guard_q) && $stable(unl_valid) && $stable(unl_sect)));
endmodule

bind sector_guard sector_guard_chk #(
  .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .NUM_SECT(NUM_SECT)
) chk (
  .clk(clk), .rst_n(rst_n), .guard_erase(guard_erase), .guard_prog(guard_prog),
  .unlock_req(unlock_req), .lock_req(lock_req), .unlock_addr(unlock_addr),
  .write_ok(write_ok), .guard_q(guard_q), .unl_valid(unl_valid), .unl_sect(unl_sect)
);

// File: tb/sector_guard_test.sv
module sector_guard_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic guard_erase = 0, guard_prog = 0, prog_bit = 0, unlock_req = 0, lock_req = 0;
  logic [23:12] prog_addr = '0, unlock_addr = '0, query_addr = '0;
  logic write_ok;

  int tests = 0, fails = 0;
  bit [511:0] mg;
  bit mv;
  bit [8:0] ms;

  always #(PERIOD/2) clk = ~clk;

  sector_guard uut (
    .clk(clk), .rst_n(rst_n), .guard_erase(guard_erase), .guard_prog(guard_prog),
    .prog_addr(prog_addr), .prog_bit(prog_bit), .unlock_req(unlock_req),
    .lock_req(lock_req), .unlock_addr(unlock_addr), .query_addr(query_addr),
    .write_ok(write_ok)
  );

  function automatic bit exp_ok(input logic [23:0] a);
    if (a[23:21] != 0) return 1'b0;
    return mg[a[20:12]] | (mv && ms == a[20:12]);
  endfunction

  task automatic check(input string req, input logic [23:0] a);
    query_addr = a[23:12];
    #1;
    tests++;
    if (write_ok !== exp_ok(a)) begin
      fails++;
      $display("FAIL %s addr=%h write_ok=%b expected=%b", req, a, write_ok, exp_ok(a));
    end
  endtask

  task automatic step(input bit er, input bit pr, input logic [23:0] pa, input bit pb,
                      input bit ul, input bit lk, input logic [23:0] ua);
    @(negedge clk);
    guard_erase = er; guard_prog = pr; prog_addr = pa[23:12]; prog_bit = pb;
    unlock_req = ul; lock_req = lk; unlock_addr = ua[23:12];
    @(posedge clk);
    if (er) mg = '1;
    else if (pr && pa[23:21] == 0) mg[pa[20:12]] = mg[pa[20:12]] & pb;
    if (lk) mv = 0;
    else if (ul && ua[23:21] == 0) begin mv = 1; ms = ua[20:12]; end
    @(negedge clk);
    guard_erase = 0; guard_prog = 0; unlock_req = 0; lock_req = 0;
  endtask

  function automatic logic [23:0] rand_addr();
    logic [23:0] a = $urandom;
    if ($urandom_range(0, 15) != 0) a[23:21] = 0;
    if ($urandom_range(0, 1) != 0) a[20:15] = 0;
    return a;
  endfunction

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mg = '1; mv = 0; ms = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1", 24'h000000); check("R1", 24'h1FF123); check("R1", 24'h0AB000);
    check("R2", 24'h200000);
    step(0, 1, 24'h005000, 0, 0, 0, 0);
    check("R4", 24'h005000); check("R6", 24'h005FFF); check("R6", 24'h006000);
    step(0, 1, 24'h005000, 1, 0, 0, 0);
    check("R4", 24'h005000);
    step(0, 1, 24'h006000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 24'h005ABC);
    check("R7", 24'h005000); check("R7", 24'h006000);
    step(0, 0, 0, 0, 1, 0, 24'h006001);
    check("R8", 24'h006FFF); check("R8", 24'h005000);
    step(0, 0, 0, 0, 1, 1, 24'h005000);
    check("R9", 24'h005000); check("R9", 24'h006000);
    step(0, 0, 0, 0, 1, 0, 24'h205000);
    check("R2", 24'h005000);
    step(0, 1, 24'h207000, 0, 0, 0, 0);
    check("R2", 24'h007000);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R11", 24'h005000); check("R11", 24'h007000);
    query_addr = 12'h006; #1; tests++;
    if (write_ok !== 1'b0) begin fails++; $display("FAIL R10 write_ok=%b expected=0", write_ok); end
    query_addr = 12'h008; #1; tests++;
    if (write_ok !== 1'b1) begin fails++; $display("FAIL R10 write_ok=%b expected=1", write_ok); end
    step(1, 1, 24'h008000, 0, 0, 0, 0);
    check("R5", 24'h008000); check("R3", 24'h005000); check("R3", 24'h006000);
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 15);
      step(op == 0, op >= 1 && op <= 7, rand_addr(), $urandom_range(0, 3) == 0,
           op >= 8 && op <= 11, op == 12, rand_addr());
      check("R6/R7", rand_addr());
      if (mv) check("R7", {3'b000, ms, 12'h000});
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule